// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides how far a small processor system powers down when its core asks to wait. The core raises a one-cycle request that says whether it waits for an interrupt or for an event. Three control bits qualify the request: deep, power-down and low-power-regulator. Together they pick one of three modes:

- **Sleep** gates only the core clock.
- **Stop** gates every clock, turns off the high-speed oscillators and the PLL, and leaves the regulator in main or low-power mode.
- **Standby** switches the regulator off and isolates the core domain.

The block drives the clock gates, oscillator and PLL enables, regulator mode, isolation flag and system-clock select from its own state register. While in a low-power mode it watches the wake sources that the current mode accepts, then sequences the return to Run. After Stop it waits for the regulator and oscillator to settle and forces the internal RC oscillator as system clock. After Standby it issues a one-cycle system reset and sets a sticky flag. A write-protect latch for the backup domain also lives here.

Top module: `lpm_sequencer`

## Requirements
- R1: In Run, a request with deep clear enters Sleep (mode_o=1). In Sleep the core clock is gated, while peripheral clocks, oscillators, PLL and main regulator (reg_mode_o=0) stay on. One cycle after a qualifying wake, the block is back in Run (mode_o=0, all clocks on).
- R2: A request with deep set and power-down clear enters Stop (mode_o=2). In Stop, both clock gates, the oscillator enable and the PLL enable are low. reg_mode_o is 1 (low-power) when the low-power-regulator bit was set at the request, and 0 (main) otherwise.
- R3: On a Stop wake, the block holds mode_o=2 with the oscillator enabled and clocks gated, then enters Run. With the main regulator it holds for MAIN_EXIT_CYC clock cycles (default 4). With the low-power regulator it holds for LP_EXIT_TICKS slow-tick pulses (default 16), and cycles without a tick do not advance the count.
- R4: A request with deep and power-down both set enters Standby (mode_o=3). In Standby, reg_mode_o=2 (off), iso_o=1, and every clock, oscillator and PLL enable is low.
- R5: Every exit from Stop leaves sysclk_sel_o at 0, the internal RC source, whatever value it had before entry. The encoding is 0 internal RC, 1 external crystal, 2 PLL. A write of clk_sel_i takes effect only in Run.
- R6: Standby exits only on one of these sources:
  - an enabled wakeup-pin rising edge
  - either RTC alarm
  - an RTC wakeup
  - a tamper event
  - a timestamp event
  - an external reset
  - a watchdog reset

  Interrupts and events are ignored in Standby. The exit is a one-cycle sys_rst_o with mode_o=3 and iso_o=1, followed by Run.
- R7: Bit i of wkup_en_i enables wakeup pin i, and a disabled pin counts as low. Only a 0-to-1 change of an enabled pin is a wake source. A pin already high when Standby is entered does not wake it.
- R8: In Sleep and Stop, a wait-for-interrupt entry (req_wfe_i=0) wakes only on irq_i. A wait-for-event entry (req_wfe_i=1) wakes only on evt_i.
- R9: After reset, bkp_wr_en_o is held low. A bkp_unlock_i pulse lets bkp_wr_req_i pass to bkp_wr_en_o. A bkp_lock_i pulse, or an exit from Standby, blocks the writes again.
- R10: A request made while a wake source for the selected mode is already active leaves the block in Run with no clock gated.
- R11: sb_flag_o is set on each exit from Standby and stays set until a sb_clr_i pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Low-power request from the core, one cycle |
| req_wfe_i | input | 1 | Request kind: 1 wait-for-event, 0 wait-for-interrupt |
| deep_i | input | 1 | Deep mode select |
| pdown_i | input | 1 | Power-down select, used with deep |
| lp_reg_i | input | 1 | Low-power regulator in Stop |
| irq_i | input | 1 | Any enabled interrupt pending |
| evt_i | input | 1 | Event input |
| wkup_pin_i | input | NUM_PINS | Wakeup pins |
| wkup_en_i | input | NUM_PINS | Per-pin wake enable |
| rtc_alarm_i | input | 2 | RTC alarm A and B |
| rtc_wake_i | input | 1 | RTC periodic wakeup |
| tamper_i | input | 1 | Tamper event |
| tstamp_i | input | 1 | Timestamp event |
| ext_rst_i | input | 1 | External reset request |
| wdg_rst_i | input | 1 | Watchdog reset request |
| slow_tick_i | input | 1 | Slow reference clock pulse |
| clk_sel_wr_i | input | 1 | System-clock select write strobe |
| clk_sel_i | input | 2 | System-clock select write value |
| bkp_unlock_i | input | 1 | Remove backup-domain write protection |
| bkp_lock_i | input | 1 | Restore backup-domain write protection |
| bkp_wr_req_i | input | 1 | Backup-domain write request |
| sb_clr_i | input | 1 | Clear standby flag |
| core_clk_en_o | output | 1 | Core clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | High-speed oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| reg_mode_o | output | 2 | Regulator: 0 main, 1 low-power, 2 off |
| iso_o | output | 1 | Core-domain isolation |
| sysclk_sel_o | output | 2 | System-clock source select |
| mode_o | output | 2 | Current mode: 0 Run, 1 Sleep, 2 Stop, 3 Standby |
| sys_rst_o | output | 1 | System reset pulse on Standby exit |
| sb_flag_o | output | 1 | Sticky woke-from-Standby flag |
| bkp_wr_en_o | output | 1 | Backup-domain write granted |

## Verification
The hardest case to reach is the low-power Stop exit, where the delay runs on slow ticks rather than clock cycles. The bench stops the tick in the middle of that delay and checks that mode_o stays at Stop for many clock cycles. It then restarts the tick and counts the exact number of ticks until Run. A second hard case is a wakeup pin that is already high when Standby is entered. The bench holds an enabled pin high across entry, and also raises a disabled pin, then checks that neither ends Standby before an RTC alarm does.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_SLEEP = 2'd1,
    MODE_STOP  = 2'd2,
    MODE_STBY  = 2'd3
  } lpm_mode_e;

  typedef enum logic [1:0] {
    REG_MAIN = 2'd0,
    REG_LP   = 2'd1,
    REG_OFF  = 2'd2
  } reg_mode_e;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_SLEEP,
    ST_STOP,
    ST_WAKE,
    ST_STBY,
    ST_RSTX
  } seq_state_e;

  localparam logic [1:0] CLK_HSI = 2'd0;
endpackage

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
  parameter int NUM_PINS = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] pin_en_i,
  input  logic [1:0]          rtc_alarm_i,
  input  logic                rtc_wake_i,
  input  logic                tamper_i,
  input  logic                tstamp_i,
  input  logic                ext_rst_i,
  input  logic                wdg_rst_i,
  input  logic                irq_i,
  input  logic                evt_i,
  input  logic                wfe_now_i,
  input  logic                wfe_held_i,
  output logic                light_now_o,
  output logic                light_held_o,
  output logic                stby_hit_o
);
  logic [NUM_PINS-1:0] pin_eff, pin_prev, pin_rise;

  // disabled pin is treated as pulled low
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign pin_eff[g] = pin_i[g] & pin_en_i[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pin_prev[g] <= 1'b0;
      else         pin_prev[g] <= pin_eff[g];
    end
    assign pin_rise[g] = pin_eff[g] & ~pin_prev[g];
  end

  assign light_now_o  = wfe_now_i  ? evt_i : irq_i;
  assign light_held_o = wfe_held_i ? evt_i : irq_i;
  assign stby_hit_o   = (|pin_rise) | (|rtc_alarm_i) | rtc_wake_i | tamper_i |
                        tstamp_i | ext_rst_i | wdg_rst_i;

  a_r7_edge_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_prev == pin_eff && !(|rtc_alarm_i) && !rtc_wake_i && !tamper_i &&
     !tstamp_i && !ext_rst_i && !wdg_rst_i) |-> !stby_hit_o);
endmodule

// File: rtl/lpm_exit_timer.sv
module lpm_exit_timer #(
  parameter int MAIN_EXIT_CYC = 4,
  parameter int LP_EXIT_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic lp_i,
  input  logic tick_i,
  input  logic active_i,
  output logic done_o
);
  localparam int MAX_CNT = (MAIN_EXIT_CYC > LP_EXIT_TICKS) ? MAIN_EXIT_CYC : LP_EXIT_TICKS;
  localparam int CNT_W   = $clog2(MAX_CNT + 1) + 1;
  localparam logic [CNT_W-1:0] MAIN_LAST = CNT_W'(MAIN_EXIT_CYC - 1);
  localparam logic [CNT_W-1:0] LP_LAST   = CNT_W'(LP_EXIT_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             lp_q;
  logic             adv;

  // low-power exit counts slow ticks, main exit counts clock cycles
  assign adv    = active_i & (lp_q ? tick_i : 1'b1);
  assign done_o = adv & (cnt_q == (lp_q ? LP_LAST : MAIN_LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lp_q  <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      lp_q  <= lp_i;
    end else if (adv && !done_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LP_LAST || cnt_q <= MAIN_LAST);
  a_r3_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && lp_q && !tick_i && !start_i) |=> $stable(cnt_q));
endmodule

// File: rtl/lpm_bkp_guard.sv
module lpm_bkp_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic unlock_i,
  input  logic lock_i,
  input  logic relock_i,
  input  logic wr_req_i,
  output logic wr_en_o
);
  logic open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  open_q <= 1'b0;
    else if (lock_i || relock_i)  open_q <= 1'b0;
    else if (unlock_i)            open_q <= 1'b1;
  end

  assign wr_en_o = wr_req_i & open_q;

  a_r9_lock_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i || relock_i) |=> !wr_en_o);
  a_r9_unlock_grants: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlock_i && !lock_i && !relock_i) |=> (wr_en_o == wr_req_i));
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int NUM_PINS      = 3,
  parameter int MAIN_EXIT_CYC = 4,
  parameter int LP_EXIT_TICKS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                req_wfe_i,
  input  logic                deep_i,
  input  logic                pdown_i,
  input  logic                lp_reg_i,
  input  logic                irq_i,
  input  logic                evt_i,
  input  logic [NUM_PINS-1:0] wkup_pin_i,
  input  logic [NUM_PINS-1:0] wkup_en_i,
  input  logic [1:0]          rtc_alarm_i,
  input  logic                rtc_wake_i,
  input  logic                tamper_i,
  input  logic                tstamp_i,
  input  logic                ext_rst_i,
  input  logic                wdg_rst_i,
  input  logic                slow_tick_i,
  input  logic                clk_sel_wr_i,
  input  logic [1:0]          clk_sel_i,
  input  logic                bkp_unlock_i,
  input  logic                bkp_lock_i,
  input  logic                bkp_wr_req_i,
  input  logic                sb_clr_i,
  output logic                core_clk_en_o,
  output logic                per_clk_en_o,
  output logic                osc_en_o,
  output logic                pll_en_o,
  output logic [1:0]          reg_mode_o,
  output logic                iso_o,
  output logic [1:0]          sysclk_sel_o,
  output logic [1:0]          mode_o,
  output logic                sys_rst_o,
  output logic                sb_flag_o,
  output logic                bkp_wr_en_o
);
  seq_state_e state_q, state_d;
  logic       wfe_q, lp_q;
  logic       light_now, light_held, stby_hit;
  logic       stop_wake, stby_exit, timer_done;
  logic [1:0] sel_q;
  logic       sb_q;

  lpm_wake_qual #(.NUM_PINS(NUM_PINS)) u_qual (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pin_i        (wkup_pin_i),
    .pin_en_i     (wkup_en_i),
    .rtc_alarm_i  (rtc_alarm_i),
    .rtc_wake_i   (rtc_wake_i),
    .tamper_i     (tamper_i),
    .tstamp_i     (tstamp_i),
    .ext_rst_i    (ext_rst_i),
    .wdg_rst_i    (wdg_rst_i),
    .irq_i        (irq_i),
    .evt_i        (evt_i),
    .wfe_now_i    (req_wfe_i),
    .wfe_held_i   (wfe_q),
    .light_now_o  (light_now),
    .light_held_o (light_held),
    .stby_hit_o   (stby_hit)
  );

  assign stop_wake = (state_q == ST_STOP) & light_held;
  assign stby_exit = (state_q == ST_STBY) & stby_hit;

  lpm_exit_timer #(
    .MAIN_EXIT_CYC (MAIN_EXIT_CYC),
    .LP_EXIT_TICKS (LP_EXIT_TICKS)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (stop_wake),
    .lp_i     (lp_q),
    .tick_i   (slow_tick_i),
    .active_i (state_q == ST_WAKE),
    .done_o   (timer_done)
  );

  lpm_bkp_guard u_bkp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .unlock_i (bkp_unlock_i),
    .lock_i   (bkp_lock_i),
    .relock_i (stby_exit),
    .wr_req_i (bkp_wr_req_i),
    .wr_en_o  (bkp_wr_en_o)
  );

  // mode select; a pending wake source keeps the block in Run
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (req_i) begin
          if (!deep_i)       state_d = light_now ? ST_RUN : ST_SLEEP;
          else if (!pdown_i) state_d = light_now ? ST_RUN : ST_STOP;
          else               state_d = stby_hit  ? ST_RUN : ST_STBY;
        end
      end
      ST_SLEEP: if (light_held) state_d = ST_RUN;
      ST_STOP:  if (light_held) state_d = ST_WAKE;
      ST_WAKE:  if (timer_done) state_d = ST_RUN;
      ST_STBY:  if (stby_hit)   state_d = ST_RSTX;
      ST_RSTX:  state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      wfe_q   <= 1'b0;
      lp_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RUN && req_i) begin
        wfe_q <= req_wfe_i;
        lp_q  <= lp_reg_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           sel_q <= CLK_HSI;
    else if (stop_wake || stby_exit)       sel_q <= CLK_HSI;
    else if (state_q == ST_RUN && clk_sel_wr_i) sel_q <= clk_sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sb_q <= 1'b0;
    else if (stby_exit) sb_q <= 1'b1;
    else if (sb_clr_i)  sb_q <= 1'b0;
  end

  assign sysclk_sel_o = sel_q;
  assign sb_flag_o    = sb_q;

  always_comb begin
    core_clk_en_o = 1'b0;
    per_clk_en_o  = 1'b0;
    osc_en_o      = 1'b0;
    pll_en_o      = 1'b0;
    reg_mode_o    = REG_MAIN;
    iso_o         = 1'b0;
    mode_o        = MODE_RUN;
    sys_rst_o     = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        core_clk_en_o = 1'b1;
        per_clk_en_o  = 1'b1;
        osc_en_o      = 1'b1;
        pll_en_o      = 1'b1;
      end
      ST_SLEEP: begin
        per_clk_en_o = 1'b1;
        osc_en_o     = 1'b1;
        pll_en_o     = 1'b1;
        mode_o       = MODE_SLEEP;
      end
      ST_STOP: begin
        reg_mode_o = lp_q ? REG_LP : REG_MAIN;
        mode_o     = MODE_STOP;
      end
      ST_WAKE: begin
        osc_en_o = 1'b1;
        mode_o   = MODE_STOP;
      end
      ST_STBY: begin
        reg_mode_o = REG_OFF;
        iso_o      = 1'b1;
        mode_o     = MODE_STBY;
      end
      ST_RSTX: begin
        iso_o     = 1'b1;
        mode_o    = MODE_STBY;
        sys_rst_o = 1'b1;
      end
      default: ;
    endcase
  end

  a_r1_core_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != MODE_RUN) |-> !core_clk_en_o);
  a_r2_stop_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && req_i && deep_i && !pdown_i && !light_now) |=> mode_o == MODE_STOP);
  a_r4_stby_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_STBY) |-> (iso_o && !osc_en_o && !per_clk_en_o));
  a_r5_hsi_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKE) |-> sysclk_sel_o == CLK_HSI);
  a_r6_rst_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> (!sys_rst_o && mode_o == MODE_RUN));
  a_r10_pending_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && req_i && !deep_i && light_now) |=> core_clk_en_o);
  a_r11_flag_on_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> sb_flag_o);
endmodule

// File: tb/lpm_sequencer_tb.sv
module lpm_sequencer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 0, req_wfe = 0, deep = 0, pdown = 0, lp_reg = 0;
  logic       irq = 0, evt = 0;
  logic [2:0] pin = '0, pin_en = '0;
  logic [1:0] alarm = '0;
  logic       rtc_wake = 0, tamper = 0, tstamp = 0, ext_rst = 0, wdg_rst = 0;
  logic       tick = 1;
  logic       sel_wr = 0;
  logic [1:0] sel_val = '0;
  logic       unlock = 0, lock = 0, bwr = 0, sb_clr = 0;
  logic       core_en, per_en, osc_en, pll_en, iso, sys_rst, sb_flag, bkp_en;
  logic [1:0] reg_mode, sysclk, mode;

  int checks = 0, errors = 0, cyc = 0;

  lpm_sequencer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_wfe_i(req_wfe),
    .deep_i(deep), .pdown_i(pdown), .lp_reg_i(lp_reg), .irq_i(irq), .evt_i(evt),
    .wkup_pin_i(pin), .wkup_en_i(pin_en), .rtc_alarm_i(alarm), .rtc_wake_i(rtc_wake),
    .tamper_i(tamper), .tstamp_i(tstamp), .ext_rst_i(ext_rst), .wdg_rst_i(wdg_rst),
    .slow_tick_i(tick), .clk_sel_wr_i(sel_wr), .clk_sel_i(sel_val),
    .bkp_unlock_i(unlock), .bkp_lock_i(lock), .bkp_wr_req_i(bwr), .sb_clr_i(sb_clr),
    .core_clk_en_o(core_en), .per_clk_en_o(per_en), .osc_en_o(osc_en), .pll_en_o(pll_en),
    .reg_mode_o(reg_mode), .iso_o(iso), .sysclk_sel_o(sysclk), .mode_o(mode),
    .sys_rst_o(sys_rst), .sb_flag_o(sb_flag), .bkp_wr_en_o(bkp_en)
  );

  always #10 clk = ~clk;

  // {mode, core, per, osc, pll, reg, iso}
  localparam logic [8:0] P_RUN    = 9'b00_1111_00_0;
  localparam logic [8:0] P_SLEEP  = 9'b01_0111_00_0;
  localparam logic [8:0] P_STOP_M = 9'b10_0000_00_0;
  localparam logic [8:0] P_STOP_L = 9'b10_0000_01_0;
  localparam logic [8:0] P_WAKE   = 9'b10_0010_00_0;
  localparam logic [8:0] P_STBY   = 9'b11_0000_10_1;
  localparam logic [8:0] P_RSTX   = 9'b11_0000_00_1;

  typedef struct {
    int         due;
    logic [8:0] val;
    string      req;
  } exp_t;
  exp_t sb_q[$];

  function automatic logic [8:0] observe();
    return {mode, core_en, per_en, osc_en, pll_en, reg_mode, iso};
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare queued expectations mid-cycle
  initial forever begin
    @(posedge clk);
    #5;
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (observe() !== e.val) begin
        errors++;
        $display("FAIL %s: cycle %0d power state %b, expected %b", e.req, cyc, observe(), e.val);
      end
    end
  end

  // expect the power vector after the next clock edge, then advance
  task automatic step_exp(logic [8:0] v, string r);
    exp_t e;
    e.due = cyc + 1;
    e.val = v;
    e.req = r;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d, expected %0d", r, act, exp);
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bwr = 1'b1;
    @(negedge clk);
    // reset state, R9 writes blocked
    chk("R1 reset mode", int'(mode), 0);
    chk("R5 reset clock select", int'(sysclk), 0);
    chk("R11 reset flag", int'(sb_flag), 0);
    chk("R9 locked after reset", int'(bkp_en), 0);

    // R1/R8: Sleep by wait-for-interrupt, an event must not wake it
    req = 1; req_wfe = 0; deep = 0;
    step_exp(P_SLEEP, "R1 sleep entry");
    req = 0; evt = 1;
    step_exp(P_SLEEP, "R8 event ignored after WFI");
    step_exp(P_SLEEP, "R8 event ignored after WFI");
    evt = 0; irq = 1;
    step_exp(P_RUN, "R1 irq wakes sleep");
    irq = 0;
    step_exp(P_RUN, "R1 stays in run");

    // R8: Sleep by wait-for-event, an interrupt must not wake it
    req = 1; req_wfe = 1;
    step_exp(P_SLEEP, "R8 sleep entry WFE");
    req = 0; irq = 1;
    step_exp(P_SLEEP, "R8 irq ignored after WFE");
    irq = 0; evt = 1;
    step_exp(P_RUN, "R8 event wakes WFE sleep");
    evt = 0;

    // R10: pending interrupt keeps Run
    irq = 1; req = 1; req_wfe = 0;
    step_exp(P_RUN, "R10 pending irq sleep request");
    req = 0; irq = 0;
    chk("R10 core clock kept", int'(core_en), 1);

    // R5: select PLL, then Stop with main regulator
    sel_wr = 1; sel_val = 2'd2;
    @(negedge clk);
    sel_wr = 0;
    chk("R5 clock select written", int'(sysclk), 2);
    req = 1; req_wfe = 0; deep = 1; pdown = 0; lp_reg = 0;
    step_exp(P_STOP_M, "R2 stop entry main");
    req = 0;
    sel_wr = 1; sel_val = 2'd1;
    step_exp(P_STOP_M, "R2 stop held");
    sel_wr = 0;
    irq = 1;
    step_exp(P_WAKE, "R3 main exit 1");
    irq = 0;
    step_exp(P_WAKE, "R3 main exit 2");
    step_exp(P_WAKE, "R3 main exit 3");
    step_exp(P_WAKE, "R3 main exit 4");
    step_exp(P_RUN, "R3 main exit done");
    chk("R5 forced internal RC after stop", int'(sysclk), 0);

    // R2/R3: Stop with low-power regulator, tick paused during exit
    sel_wr = 1; sel_val = 2'd2;
    @(negedge clk);
    sel_wr = 0;
    req = 1; lp_reg = 1;
    step_exp(P_STOP_L, "R2 stop entry low-power");
    req = 0; lp_reg = 0;
    step_exp(P_STOP_L, "R2 low-power regulator held");
    irq = 1; tick = 0;
    step_exp(P_WAKE, "R3 lp exit entry");
    irq = 0;
    for (int i = 0; i < 20; i++) step_exp(P_WAKE, "R3 no tick no progress");
    tick = 1;
    for (int i = 0; i < 15; i++) step_exp(P_WAKE, "R3 lp exit counting");
    step_exp(P_RUN, "R3 lp exit done after 16 ticks");
    chk("R5 forced internal RC after lp stop", int'(sysclk), 0);

    // R9: unlock backup writes
    unlock = 1;
    @(negedge clk);
    unlock = 0;
    chk("R9 unlocked write passes", int'(bkp_en), 1);

    // R4/R6/R7: Standby, exit by enabled pin rising edge
    pin_en = 3'b001;
    req = 1; deep = 1; pdown = 1;
    step_exp(P_STBY, "R4 standby entry");
    req = 0; irq = 1; evt = 1;
    step_exp(P_STBY, "R6 irq and event ignored in standby");
    irq = 0; evt = 0; pin[2] = 1;
    step_exp(P_STBY, "R7 disabled pin ignored");
    step_exp(P_STBY, "R7 disabled pin ignored");
    pin[0] = 1;
    step_exp(P_RSTX, "R6 pin edge exits standby");
    chk("R6 reset pulse", int'(sys_rst), 1);
    step_exp(P_RUN, "R6 run after reset");
    chk("R6 reset pulse one cycle", int'(sys_rst), 0);
    chk("R11 flag set", int'(sb_flag), 1);
    chk("R9 relocked on standby exit", int'(bkp_en), 0);

    // R7: pin held high across entry does not wake; alarm does
    req = 1;
    step_exp(P_STBY, "R7 standby with pin high");
    req = 0;
    for (int i = 0; i < 4; i++) step_exp(P_STBY, "R7 level-high pin ignored");
    alarm = 2'b10;
    step_exp(P_RSTX, "R6 alarm B exits standby");
    alarm = 2'b00;
    step_exp(P_RUN, "R6 run after alarm");
    pin = '0;
    sb_clr = 1;
    @(negedge clk);
    sb_clr = 0;
    chk("R11 flag cleared", int'(sb_flag), 0);

    // R6: watchdog reset as wake source
    req = 1;
    step_exp(P_STBY, "R4 standby entry again");
    req = 0;
    wdg_rst = 1;
    step_exp(P_RSTX, "R6 watchdog exits standby");
    wdg_rst = 0;
    step_exp(P_RUN, "R6 run after watchdog");

    // R10: standby request with tamper pending
    tamper = 1; req = 1;
    step_exp(P_RUN, "R10 pending tamper keeps run");
    req = 0; tamper = 0;
    chk("R11 flag stays set", int'(sb_flag), 1);

    // R9: lock blocks writes
    unlock = 1;
    @(negedge clk);
    unlock = 0; lock = 1;
    @(negedge clk);
    lock = 0;
    chk("R9 lock blocks write", int'(bkp_en), 0);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule